// File: doc/BRIEF.md
# Card Memory Command Framer with Serial CRC-4

This block prepares single-byte read and write commands for a contactless memory card and checks the integrity byte of read responses. A request carries a card format code, a byte address, a data byte for writes, an operation select and, for reads, the 12-bit response from the card. The format code sets the width of the address field and the card capacity. The block then runs a 4-bit CRC, one bit per clock, over the command flag, the address field and the data byte.

After the CRC finishes, the block presents the command word and its bit length. For a read it also presents the received data byte and a flag that shows whether the received CRC nibble matches the computed one. Two kinds of request produce no command and finish at once: a write aimed at the protected low addresses, and a request with an unknown format code. Driving the command onto the air and applying any keystream are left to the surrounding logic.

Top module: `card_cmd_framer`

## Requirements
- R1: Format code 0x0D gives a 5-bit address field and mem_bytes_o=22. Code 0x1D gives 8 bits and 256. Code 0x3D gives 10 bits and 1024.
- R2: A read produces cmd_o = (addr << 1) | 1 with cmd_len_o = address width + 1. All bits of cmd_o above the length are zero.
- R3: A write produces cmd_o with bit 0 = 0, the address in bits [aw:1], the data byte in bits [aw+8:aw+1] and the CRC nibble in bits [aw+12:aw+9], with cmd_len_o = aw + 13.
- R4: The CRC preset is 0x5. For each input bit b, taken LSB first: fb = crc[0]^b, then crc = crc>>1, and crc is XORed with 0xC when fb=1. The bits are fed in this order: the operation flag (1 for read, 0 for write), then the aw address bits, then 8 data bits (wdata_i for a write, resp_i[7:0] for a read). crc_o gives the final value.
- R5: For a read, rdata_o = resp_i[7:0], and crc_err_o = 1 exactly when resp_i[11:8] differs from the computed CRC. A write always gives crc_err_o = 0.
- R6: A write whose masked address is 0 to 4 is refused. It gives refused_o=1, cmd_o=0 and cmd_len_o=0, and done_o rises on the same edge that samples start_i.
- R7: An accepted request raises busy_o. done_o then pulses on the clock edge exactly 1 + aw + 8 edges after the edge that sampled start_i.
- R8: An unknown format code gives type_err_o=1, cmd_o=0, cmd_len_o=0 and mem_bytes_o=0, and done_o rises on the edge that samples start_i.
- R9: start_i is ignored while busy_o is high. The running request completes unchanged, and no extra done_o follows.
- R10: Address bits at or above the selected address width are ignored.
- R11: While rst_ni is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled when idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| card_type_i | input | 8 | Card format code |
| addr_i | input | 10 | Byte address |
| wdata_i | input | 8 | Write data byte |
| resp_i | input | 12 | Read response: CRC in [11:8], data in [7:0] |
| busy_o | output | 1 | CRC run in progress |
| done_o | output | 1 | Result valid pulse |
| cmd_o | output | 23 | Command word, LSB sent first |
| cmd_len_o | output | 5 | Command length in bits |
| crc_o | output | 4 | Computed CRC |
| rdata_o | output | 8 | Read data byte |
| crc_err_o | output | 1 | Read CRC mismatch |
| type_err_o | output | 1 | Unknown format code |
| refused_o | output | 1 | Write to protected address refused |
| mem_bytes_o | output | 11 | Card capacity in bytes |

## Verification
The bench sweeps all three formats over low and high addresses, reads with matching and corrupted CRC nibbles, and writes. A CRC that took the bits in the wrong order or with the wrong preset would show up as a wrong nibble in the write word and as false mismatch flags on reads. The writes to addresses 4 and 5, where the protected range ends, catch an off-by-one refusal. Addresses with junk above the field width catch an address that is not masked. Counting done latency per format catches an engine that runs one bit short or long. A second start inside a busy window catches a design that re-arms or picks up the new inputs.

// File: rtl/card_cmd_pkg.sv
package card_cmd_pkg;
  localparam int TYPE_W  = 8;
  localparam int AWF_W   = 4;
  localparam int BYTES_W = 11;
  localparam int NUM_FMT = 3;

  typedef struct packed {
    logic [TYPE_W-1:0]  code;
    logic [AWF_W-1:0]   aw;
    logic [BYTES_W-1:0] bytes;
  } card_fmt_t;

  function automatic card_fmt_t fmt_at(input int idx);
    card_fmt_t f;
    case (idx)
      0:       f = '{code: 8'h0D, aw: 4'd5,  bytes: 11'd22};
      1:       f = '{code: 8'h1D, aw: 4'd8,  bytes: 11'd256};
      default: f = '{code: 8'h3D, aw: 4'd10, bytes: 11'd1024};
    endcase
    return f;
  endfunction
endpackage

// File: rtl/card_fmt_decode.sv
module card_fmt_decode
  import card_cmd_pkg::*;
(
  input  logic [TYPE_W-1:0]  code_i,
  output logic               valid_o,
  output logic [AWF_W-1:0]   aw_o,
  output logic [BYTES_W-1:0] bytes_o
);
  logic [NUM_FMT-1:0] hit;

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    assign hit[g] = (code_i == fmt_at(g).code);
  end

  always_comb begin
    valid_o = |hit;
    aw_o    = '0;
    bytes_o = '0;
    for (int i = 0; i < NUM_FMT; i++) begin
      if (hit[i]) begin
        aw_o    = aw_o | fmt_at(i).aw;
        bytes_o = bytes_o | fmt_at(i).bytes;
      end
    end
    assert_type_onehot_R1: assert ($onehot0(hit));
  end
endmodule

// File: rtl/crc4_serial_engine.sv
module crc4_serial_engine #(
  parameter int               STREAM_W = 19,
  parameter int               CNT_W    = 5,
  parameter int               CRC_W    = 4,
  parameter logic [CRC_W-1:0] POLY     = 4'hC,
  parameter logic [CRC_W-1:0] INIT     = 4'h5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [STREAM_W-1:0] stream_i,
  input  logic [CNT_W-1:0]    nbits_i,
  output logic                busy_o,
  output logic                last_o,
  output logic [CRC_W-1:0]    crc_nxt_o
);
  logic [STREAM_W-1:0] sh_q;
  logic [CNT_W-1:0]    cnt_q, nbits_q;
  logic [CRC_W-1:0]    crc_q;
  logic                busy_q, fb;

  always_comb begin
    fb        = crc_q[0] ^ sh_q[0];
    crc_nxt_o = (crc_q >> 1) ^ (fb ? POLY : '0);
    last_o    = busy_q && (cnt_q == nbits_q - CNT_W'(1));
  end

  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      nbits_q <= '0;
      crc_q   <= '0;
      busy_q  <= 1'b0;
    end else if (load_i) begin
      sh_q    <= stream_i;
      cnt_q   <= '0;
      nbits_q <= nbits_i;
      crc_q   <= INIT;
      busy_q  <= 1'b1;
    end else if (busy_q) begin
      sh_q  <= sh_q >> 1;
      crc_q <= crc_nxt_o;
      cnt_q <= cnt_q + CNT_W'(1);
      if (last_o) busy_q <= 1'b0;
    end
  end

  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < nbits_q));
  assert_load_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_q);
  assert_start_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (cnt_q == '0) && (crc_q == INIT));
endmodule

// File: rtl/card_cmd_framer.sv
module card_cmd_framer
  import card_cmd_pkg::*;
#(
  parameter int             ADDR_W_MAX = 10,
  parameter int             DATA_W     = 8,
  parameter int             CRC_W      = 4,
  parameter logic [CRC_W-1:0] CRC_POLY = 4'hC,
  parameter logic [CRC_W-1:0] CRC_INIT = 4'h5,
  parameter int             PROT_LAST  = 4,
  localparam int            STREAM_W   = 1 + ADDR_W_MAX + DATA_W,
  localparam int            CMD_W      = STREAM_W + CRC_W,
  localparam int            CNT_W      = $clog2(STREAM_W + 1),
  localparam int            LEN_W      = $clog2(CMD_W + 1),
  localparam int            RESP_W     = DATA_W + CRC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               wr_i,
  input  logic [TYPE_W-1:0]  card_type_i,
  input  logic [ADDR_W_MAX-1:0] addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [RESP_W-1:0]  resp_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [CMD_W-1:0]   cmd_o,
  output logic [LEN_W-1:0]   cmd_len_o,
  output logic [CRC_W-1:0]   crc_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               crc_err_o,
  output logic               type_err_o,
  output logic               refused_o,
  output logic [BYTES_W-1:0] mem_bytes_o
);
  logic                  type_ok, refuse_d, accept, load, last;
  logic [AWF_W-1:0]      aw_d;
  logic [BYTES_W-1:0]    bytes_d;
  logic [ADDR_W_MAX-1:0] addr_m_d;
  logic [DATA_W-1:0]     crc_data_d;
  logic [STREAM_W-1:0]   stream_d;
  logic [CNT_W-1:0]      nbits_d;
  logic [CRC_W-1:0]      crc_nxt;

  logic                  op_wr_q;
  logic [AWF_W-1:0]      aw_q;
  logic [ADDR_W_MAX-1:0] addr_q;
  logic [DATA_W-1:0]     data_q;
  logic [CRC_W-1:0]      rcrc_q;
  logic [BYTES_W-1:0]    bytes_q;

  logic [CMD_W-1:0]      asm_cmd;
  logic [LEN_W-1:0]      asm_len;

  card_fmt_decode u_dec (
    .code_i  (card_type_i),
    .valid_o (type_ok),
    .aw_o    (aw_d),
    .bytes_o (bytes_d)
  );

  // request decode: mask address, pick CRC data, build LSB-first stream
  always_comb begin
    addr_m_d   = addr_i & ~({ADDR_W_MAX{1'b1}} << aw_d);
    refuse_d   = wr_i && (addr_m_d <= ADDR_W_MAX'(PROT_LAST));
    accept     = start_i && !busy_o;
    load       = accept && type_ok && !refuse_d;
    crc_data_d = wr_i ? wdata_i : resp_i[DATA_W-1:0];
    stream_d   = STREAM_W'(!wr_i)
               | (STREAM_W'(addr_m_d) << 1)
               | (STREAM_W'(crc_data_d) << (CNT_W'(aw_d) + CNT_W'(1)));
    nbits_d    = CNT_W'(aw_d) + CNT_W'(1 + DATA_W);
  end

  crc4_serial_engine #(
    .STREAM_W (STREAM_W),
    .CNT_W    (CNT_W),
    .CRC_W    (CRC_W),
    .POLY     (CRC_POLY),
    .INIT     (CRC_INIT)
  ) u_crc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .stream_i  (stream_d),
    .nbits_i   (nbits_d),
    .busy_o    (busy_o),
    .last_o    (last),
    .crc_nxt_o (crc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_wr_q <= 1'b0;
      aw_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      rcrc_q  <= '0;
      bytes_q <= '0;
    end else if (load) begin
      op_wr_q <= wr_i;
      aw_q    <= aw_d;
      addr_q  <= addr_m_d;
      data_q  <= crc_data_d;
      rcrc_q  <= resp_i[RESP_W-1:DATA_W];
      bytes_q <= bytes_d;
    end
  end

  // command word assembly from captured fields and final CRC
  always_comb begin
    if (op_wr_q) begin
      asm_cmd = (CMD_W'(crc_nxt) << (LEN_W'(aw_q) + LEN_W'(1 + DATA_W)))
              | (CMD_W'(data_q) << (LEN_W'(aw_q) + LEN_W'(1)))
              | (CMD_W'(addr_q) << 1);
      asm_len = LEN_W'(aw_q) + LEN_W'(1 + DATA_W + CRC_W);
    end else begin
      asm_cmd = (CMD_W'(addr_q) << 1) | CMD_W'(1);
      asm_len = LEN_W'(aw_q) + LEN_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      cmd_o       <= '0;
      cmd_len_o   <= '0;
      crc_o       <= '0;
      rdata_o     <= '0;
      crc_err_o   <= 1'b0;
      type_err_o  <= 1'b0;
      refused_o   <= 1'b0;
      mem_bytes_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept && !load) begin
        done_o      <= 1'b1;
        cmd_o       <= '0;
        cmd_len_o   <= '0;
        crc_o       <= '0;
        rdata_o     <= '0;
        crc_err_o   <= 1'b0;
        type_err_o  <= !type_ok;
        refused_o   <= type_ok;
        mem_bytes_o <= type_ok ? bytes_d : '0;
      end else if (last) begin
        done_o      <= 1'b1;
        cmd_o       <= asm_cmd;
        cmd_len_o   <= asm_len;
        crc_o       <= crc_nxt;
        rdata_o     <= op_wr_q ? '0 : data_q;
        crc_err_o   <= !op_wr_q && (crc_nxt != rcrc_q);
        type_err_o  <= 1'b0;
        refused_o   <= 1'b0;
        mem_bytes_o <= bytes_q;
      end
    end
  end

  assert_refused_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && refused_o) |-> (cmd_len_o == '0) && (cmd_o == '0) && !type_err_o);
  assert_bad_type_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && type_err_o) |-> (cmd_len_o == '0) && (mem_bytes_o == '0));
  assert_read_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !type_err_o && !refused_o && !op_wr_q) |-> cmd_o[0]);
  assert_write_noerr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_wr_q) |-> !crc_err_o);
  assert_hold_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last) |=> $stable(op_wr_q) && $stable(aw_q) && $stable(addr_q));
  assert_done_at_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

// File: tb/card_cmd_framer_tb.sv
module card_cmd_framer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  ctype = 8'h00;
  logic [9:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [11:0] resp = '0;
  logic        busy, done, crc_err, type_err, refused;
  logic [22:0] cmd;
  logic [4:0]  cmd_len;
  logic [3:0]  crc;
  logic [7:0]  rdata;
  logic [10:0] mem_bytes;

  int errors = 0;
  int checks = 0;
  int lat = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_cmd_framer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wr_i(wr),
    .card_type_i(ctype), .addr_i(addr), .wdata_i(wdata), .resp_i(resp),
    .busy_o(busy), .done_o(done), .cmd_o(cmd), .cmd_len_o(cmd_len),
    .crc_o(crc), .rdata_o(rdata), .crc_err_o(crc_err),
    .type_err_o(type_err), .refused_o(refused), .mem_bytes_o(mem_bytes)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_crc(input int aw, input int flag, input int a, input int d);
    logic [3:0] c = 4'h5;
    for (int i = 0; i < aw + 9; i++) begin
      int b;
      if (i == 0) b = flag;
      else if (i <= aw) b = (a >> (i - 1)) & 1;
      else b = (d >> (i - 1 - aw)) & 1;
      if ((c[0] ^ b[0]) == 1'b1) c = (c >> 1) ^ 4'hC;
      else c = c >> 1;
    end
    return c;
  endfunction

  task automatic run_op(input logic [7:0] ty, input logic w, input logic [9:0] a,
                        input logic [7:0] d, input logic [11:0] r);
    @(negedge clk);
    ctype = ty; wr = w; addr = a; wdata = d; resp = r; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    if (!done) chk("R7", "watchdog done", 0, 1);
  endtask

  // full check of one valid-format request
  task automatic check_valid(input int t, input int aw, input int nb, input logic w,
                             input int araw, input int d, input int flip);
    int am = araw & ((1 << aw) - 1);
    logic [3:0] ec;
    longint ecmd;
    if (w) ec = ref_crc(aw, 0, am, d);
    else   ec = ref_crc(aw, 1, am, d);
    run_op(t[7:0], w, araw[9:0], w ? d[7:0] : 8'h00,
           w ? 12'h000 : {ec ^ flip[3:0], d[7:0]});
    chk("R1", "mem_bytes", mem_bytes, nb);
    if (w && am <= 4) begin
      chk("R6", "refused", refused, 1);
      chk("R6", "cmd_len", cmd_len, 0);
      chk("R6", "cmd", cmd, 0);
      chk("R6", "latency", lat, 0);
    end else begin
      chk("R7", "latency", lat, aw + 9);
      chk("R4", "crc", crc, ec);
      chk("R6", "refused", refused, 0);
      if (w) begin
        ecmd = (longint'(ec) << (aw + 9)) | (longint'(d) << (aw + 1)) | (longint'(am) << 1);
        chk("R3", "cmd", cmd, ecmd);
        chk("R3", "cmd_len", cmd_len, aw + 13);
        chk("R5", "write crc_err", crc_err, 0);
      end else begin
        ecmd = (longint'(am) << 1) | 1;
        chk("R2", "cmd", cmd, ecmd);
        chk("R2", "cmd_len", cmd_len, aw + 1);
        chk("R5", "rdata", rdata, d);
        chk("R5", "crc_err", crc_err, (flip != 0) ? 1 : 0);
      end
      if (araw != am) chk("R10", "masked addr in cmd", (cmd >> 1) & ((1 << aw) - 1), am);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    chk("R7", "global watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int codes[3] = '{8'h0D, 8'h1D, 8'h3D};
    int aws[3]   = '{5, 8, 10};
    int nbs[3]   = '{22, 256, 1024};
    int bad[6]   = '{8'h00, 8'h0C, 8'h1E, 8'h2D, 8'h4D, 8'hFF};

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11", "done", done, 0);
    chk("R11", "busy", busy, 0);
    chk("R11", "cmd", cmd, 0);
    chk("R11", "flags", {crc_err, type_err, refused}, 0);
    chk("R11", "mem_bytes", mem_bytes, 0);
    rst_n = 1'b1;

    for (int t = 0; t < 3; t++) begin
      for (int k = 0; k < 40; k++) begin
        int araw = (k < 8) ? k : ((k * 53 + 11 + t * 97) & 10'h3FF);
        int d = (k * 29 + t * 7 + 3) & 8'hFF;
        check_valid(codes[t], aws[t], nbs[t], 1'b0, araw, d, 0);
        check_valid(codes[t], aws[t], nbs[t], 1'b0, araw, d, (k % 15) + 1);
        check_valid(codes[t], aws[t], nbs[t], 1'b1, araw, d, 0);
      end
      // R10: address with junk above the field hitting protected range
      check_valid(codes[t], aws[t], nbs[t], 1'b1, (10'h3FF << aws[t]) & 10'h3FF | 3, 8'hA5, 0);
      check_valid(codes[t], aws[t], nbs[t], 1'b1, (10'h3FF << aws[t]) & 10'h3FF | 5, 8'h5A, 0);
    end

    // R8 unknown format codes
    for (int i = 0; i < 6; i++) begin
      run_op(bad[i][7:0], i[0], 10'h155, 8'h33, 12'hABC);
      chk("R8", "type_err", type_err, 1);
      chk("R8", "cmd", cmd, 0);
      chk("R8", "cmd_len", cmd_len, 0);
      chk("R8", "mem_bytes", mem_bytes, 0);
      chk("R8", "latency", lat, 0);
    end

    // R9 start during busy ignored
    begin
      logic [3:0] ec = ref_crc(8, 1, 8'h40, 8'h77);
      @(negedge clk);
      ctype = 8'h1D; wr = 1'b0; addr = 10'h040; resp = {ec, 8'h77}; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      repeat (3) begin @(posedge clk); lat++; @(negedge clk); end
      chk("R9", "busy mid-run", busy, 1);
      ctype = 8'h0D; wr = 1'b1; addr = 10'h007; wdata = 8'h11; resp = 12'h000; start = 1'b1;
      @(posedge clk); lat++;
      @(negedge clk);
      start = 1'b0;
      while (!done && lat < 200) begin @(posedge clk); lat++; @(negedge clk); end
      chk("R9", "latency of first", lat, 17);
      chk("R9", "cmd of first", cmd, 23'h081);
      chk("R9", "len of first", cmd_len, 9);
      chk("R9", "crc_err of first", crc_err, 0);
      begin
        int extra = 0;
        repeat (25) begin @(posedge clk); @(negedge clk); if (done) extra++; end
        chk("R9", "no extra done", extra, 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule